// File: doc/BRIEF.md
# Ping-Pong Ethernet Receive Frame Buffer

This block takes Ethernet frames from a 4-bit media-independent receive interface and parks them in a 4096-byte store. The store is split into two halves of 512 words, and frames land in the halves by turns, so software can drain one frame while the next one arrives. On the line side, nibbles are paired into bytes and bytes are packed into 32-bit words. The preamble and the start delimiter are removed. A running CRC is kept, and a frame that completes makes its half full.

Word 0 of each half is a control slot. Its top bit says that the half holds a frame for software, and bits [27:16] hold the frame length in bytes. Software reads the frame through a word-addressed port with a byte-lane shift. It hands the half back by writing a zero into the top byte of the control slot. The full and release events cross between the line clock and the processor clock as toggles through two-flop synchronisers. Bad CRC, short frames, dropped frames and oversize frames each set a sticky bit of an error vector.

Top module: `eth_rx_pingpong`

## Requirements
- R1: After reset, the control words at word addresses 0x000 and 0x200 read 0, and err_o reads 0.
- R2: Nibbles are taken low nibble first. Everything up to and including the 0xD5 delimiter is removed. Frame byte k (counting from the first byte after 0xD5, FCS included) is stored in word 1+k/4 of its half, in bits [8*(k%4)+7 : 8*(k%4)]. Lanes of a last partial word that receive no byte read 0.
- R3: The control word holds bit 31 = 1 (full) and bits [27:16] = frame length in bytes including the FCS, with all other bits 0. It reads as all zeros while the half is empty. It is published only after every payload word of the frame has been written, and payload writes never target word 0.
- R4: Completed frames go to half 0, then half 1, then half 0, and so on. Word-address bit 9 selects the half. A dropped frame does not advance this order.
- R5: A release is a write with cpu_we_i[3]=1 and cpu_wdata_i[31]=0 to word 0 of a full half; the half then reads as empty from the next read on. A write with bit 31 set, a write without the top byte enable, and any write to a payload word leave the stored contents unchanged.
- R6: When a frame's delimiter arrives while the next half is still full, the frame is dropped and err_o[1] is set. Both halves keep their contents, and the full flag of a half changes only through a completed frame or a release.
- R7: A frame whose CRC-32 over all bytes, FCS included, does not leave the residue 0xDEBB20E3 sets err_o[0]. The frame is still stored and published.
- R8: A frame shorter than 64 bytes, FCS included, sets err_o[2]. The frame is still stored and published.
- R9: A frame longer than 2044 bytes is dropped, err_o[3] is set, and no half becomes full.
- R10: Read data appears on cpu_rdata_o one clock after the address is presented. It equals the addressed word shifted right by 8 × cpu_lane_i bits.
- R11: Error bits stay set until reset, and err_o[7:4] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| mii_clk_i | input | 1 | Receive clock from the PHY |
| mii_dv_i | input | 1 | Receive data valid |
| mii_d_i | input | 4 | Receive nibble |
| cpu_addr_i | input | 10 | Word address: bit 9 selects the half, bits [8:0] select the word |
| cpu_lane_i | input | 2 | Byte offset that selects the read shift |
| cpu_we_i | input | 4 | Byte write enables |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Registered read data |
| err_o | output | 8 | Sticky errors: [0] CRC, [1] dropped because the next half is full, [2] short, [3] oversize |

## Verification
The hardest state to reach is a frame that arrives while the next half is still full. From the ports this needs both halves filled and held unreleased across the whole following frame. The bench sends two frames without releasing either one, then sends a third. It checks that err_o[1] rises, that both control words and the earlier payload are intact, and that the next accepted frame still lands in half 0. The oversize drop is reached with a single frame of 2049 bytes, and the check that follows confirms that neither half became full.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_PRE,
    RX_DATA,
    RX_DROP,
    RX_COMMIT
  } rx_state_e;

  localparam int unsigned ERR_CRC   = 0;
  localparam int unsigned ERR_OVF   = 1;
  localparam int unsigned ERR_SHORT = 2;
  localparam int unsigned ERR_LONG  = 3;

  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;
  localparam logic [3:0]  SFD_UPPER   = 4'hD;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxpp_sync.sv
// Two-flop synchroniser with asynchronous clear. Fed with a constant 1,
// it doubles as a reset synchroniser.
module rxpp_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end

    assign q_o[i] = sync_q;
  end

endmodule

// File: rtl/rxpp_ram.sv
// Simple dual-clock memory: the write port is on the line clock and the
// registered read port is on the processor clock.
module rxpp_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 32
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/rxpp_mii_rx.sv
// Line-side receiver: strips the preamble, assembles nibbles into bytes and
// words, tracks the CRC, and publishes a frame by toggling the set flag of its half.
module rxpp_mii_rx
  import rxpp_pkg::*;
#(
  parameter int unsigned BUF_AW    = 9,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned MIN_BYTES = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dv_i,
  input  logic [3:0]            d_i,
  input  logic [1:0]            full_i,
  output logic                  we_o,
  output logic [BUF_AW:0]       waddr_o,
  output logic [31:0]           wdata_o,
  output logic [1:0]            set_tgl_o,
  output logic [1:0][LEN_W-1:0] len_o,
  output logic [7:0]            err_o
);

  localparam int unsigned CAP_BYTES = ((1 << BUF_AW) - 1) * 4;
  localparam logic [LEN_W-1:0] CAP_CNT = LEN_W'(CAP_BYTES);
  localparam logic [LEN_W-1:0] MIN_CNT = LEN_W'(MIN_BYTES);

  rx_state_e             state_q, state_n;
  logic                  cur_q, cur_n;
  logic                  hi_q, hi_n;
  logic [3:0]            lo_q, lo_n;
  logic [LEN_W-1:0]      cnt_q, cnt_n;
  logic [31:0]           acc_q, acc_n;
  logic [31:0]           crc_q, crc_n;
  logic                  we_q, we_n;
  logic [BUF_AW:0]       waddr_q, waddr_n;
  logic [31:0]           wdata_q, wdata_n;
  logic [1:0]            set_q, set_n;
  logic [1:0][LEN_W-1:0] len_q, len_n;
  logic [7:0]            err_q, err_n;
  logic                  dv_q;
  logic [3:0]            d_q;

  logic [1:0]        lane;
  logic [BUF_AW-1:0] widx;
  logic [7:0]        new_byte;
  logic              sfd_hit;

  assign lane     = cnt_q[1:0];
  assign widx     = BUF_AW'(cnt_q[LEN_W-1:2]) + BUF_AW'(1);
  assign new_byte = {d_q, lo_q};
  assign sfd_hit  = dv_q && (d_q == SFD_UPPER);

  always_comb begin
    state_n = state_q;
    cur_n   = cur_q;
    hi_n    = hi_q;
    lo_n    = lo_q;
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    crc_n   = crc_q;
    we_n    = 1'b0;
    waddr_n = waddr_q;
    wdata_n = wdata_q;
    set_n   = set_q;
    len_n   = len_q;
    err_n   = err_q;

    unique case (state_q)
      RX_IDLE, RX_PRE: begin
        if (!dv_q) begin
          state_n = RX_IDLE;
        end else if (sfd_hit) begin
          if (full_i[cur_q]) begin
            state_n        = RX_DROP;
            err_n[ERR_OVF] = 1'b1;
          end else begin
            state_n = RX_DATA;
            cnt_n   = '0;
            hi_n    = 1'b0;
            acc_n   = '0;
            crc_n   = CRC_INIT;
          end
        end else begin
          state_n = RX_PRE;
        end
      end

      RX_DATA: begin
        if (!dv_q) begin
          // End of frame: flush a partial word, record length and errors.
          if (lane != 2'd0) begin
            we_n    = 1'b1;
            waddr_n = {cur_q, widx};
            wdata_n = acc_q;
          end
          len_n[cur_q] = cnt_q;
          if (crc_q != CRC_RESIDUE) err_n[ERR_CRC]   = 1'b1;
          if (cnt_q < MIN_CNT)      err_n[ERR_SHORT] = 1'b1;
          state_n = RX_COMMIT;
        end else if (!hi_q) begin
          lo_n = d_q;
          hi_n = 1'b1;
        end else begin
          hi_n = 1'b0;
          if (cnt_q == CAP_CNT) begin
            state_n         = RX_DROP;
            err_n[ERR_LONG] = 1'b1;
          end else begin
            crc_n = crc32_step(crc_q, new_byte);
            cnt_n = cnt_q + LEN_W'(1);
            acc_n[{lane, 3'b000} +: 8] = new_byte;
            if (lane == 2'd3) begin
              we_n    = 1'b1;
              waddr_n = {cur_q, widx};
              wdata_n = {new_byte, acc_q[23:0]};
              acc_n   = '0;
            end
          end
        end
      end

      RX_DROP: begin
        if (!dv_q) state_n = RX_IDLE;
      end

      RX_COMMIT: begin
        // The payload write issued last cycle lands on the same edge as this toggle.
        set_n[cur_q] = ~set_q[cur_q];
        cur_n        = ~cur_q;
        state_n      = RX_IDLE;
      end

      default: state_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q    <= 1'b0;
      d_q     <= '0;
      state_q <= RX_IDLE;
      cur_q   <= 1'b0;
      hi_q    <= 1'b0;
      lo_q    <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      crc_q   <= CRC_INIT;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      set_q   <= '0;
      len_q   <= '0;
      err_q   <= '0;
    end else begin
      dv_q    <= dv_i;
      d_q     <= d_i;
      state_q <= state_n;
      cur_q   <= cur_n;
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      cnt_q   <= cnt_n;
      acc_q   <= acc_n;
      crc_q   <= crc_n;
      we_q    <= we_n;
      if (we_n) begin
        waddr_q <= waddr_n;
        wdata_q <= wdata_n;
      end
      set_q   <= set_n;
      len_q   <= len_n;
      err_q   <= err_n;
    end
  end

  assign we_o      = we_q;
  assign waddr_o   = waddr_q;
  assign wdata_o   = wdata_q;
  assign set_tgl_o = set_q;
  assign len_o     = len_q;
  assign err_o     = err_q;

endmodule

// File: rtl/rxpp_cpu_port.sv
// Processor-side port: release decode, the control-slot view and the
// registered, lane-shifted read path.
module rxpp_cpu_port #(
  parameter int unsigned BUF_AW = 9,
  parameter int unsigned LEN_W  = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [BUF_AW:0]       addr_i,
  input  logic [1:0]            lane_i,
  input  logic [3:0]            we_i,
  input  logic [31:0]           wdata_i,
  input  logic [1:0]            set_sync_i,
  input  logic [1:0][LEN_W-1:0] len_i,
  input  logic [31:0]           ram_q_i,
  output logic [31:0]           rdata_o,
  output logic [1:0]            clr_tgl_o,
  output logic [1:0]            full_o,
  output logic [1:0]            rel_o
);

  localparam int unsigned PAD_W = 15 - LEN_W;

  logic [1:0]  clr_q, clr_n;
  logic        sel_ctrl_q;
  logic [1:0]  lane_q;
  logic [31:0] ctrl_q, ctrl_n;
  logic        ctrl_hit;
  logic        bsel;
  logic [31:0] word_sel;

  assign full_o   = set_sync_i ^ clr_q;
  assign ctrl_hit = (addr_i[BUF_AW-1:0] == '0);
  assign bsel     = addr_i[BUF_AW];

  for (genvar b = 0; b < 2; b++) begin : g_rel
    assign rel_o[b] = we_i[3] & ~wdata_i[31] & ctrl_hit & (bsel == 1'(b)) & full_o[b];
  end

  assign clr_n = clr_q ^ rel_o;

  always_comb begin
    if (full_o[bsel]) ctrl_n = {1'b1, {PAD_W{1'b0}}, len_i[bsel], 16'h0000};
    else              ctrl_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q      <= '0;
      sel_ctrl_q <= 1'b1;
      lane_q     <= '0;
      ctrl_q     <= '0;
    end else begin
      clr_q      <= clr_n;
      sel_ctrl_q <= ctrl_hit;
      lane_q     <= lane_i;
      ctrl_q     <= ctrl_n;
    end
  end

  assign word_sel  = sel_ctrl_q ? ctrl_q : ram_q_i;
  assign rdata_o   = word_sel >> {lane_q, 3'b000};
  assign clr_tgl_o = clr_q;

endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong #(
  parameter int unsigned BUF_AW    = 9,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned MIN_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mii_clk_i,
  input  logic              mii_dv_i,
  input  logic [3:0]        mii_d_i,
  input  logic [BUF_AW:0]   cpu_addr_i,
  input  logic [1:0]        cpu_lane_i,
  input  logic [3:0]        cpu_we_i,
  input  logic [31:0]       cpu_wdata_i,
  output logic [31:0]       cpu_rdata_o,
  output logic [7:0]        err_o
);

  localparam int unsigned MEM_AW = BUF_AW + 1;

  logic                  cpu_rst_n;
  logic                  mii_rst_n;
  logic [1:0]            set_tgl;
  logic [1:0]            set_sync;
  logic [1:0]            clr_tgl;
  logic [1:0]            clr_sync;
  logic [1:0]            full_mii;
  logic [1:0]            full_cpu;
  logic [1:0]            rel;
  logic                  mem_we;
  logic [MEM_AW-1:0]     mem_waddr;
  logic [31:0]           mem_wdata;
  logic [31:0]           ram_q;
  logic [1:0][LEN_W-1:0] len_vec;
  logic [7:0]            err_mii;

  rxpp_sync #(.W(1)) u_rst_cpu (
    .clk_i (clk_i),     .rst_ni (rst_ni), .d_i (1'b1), .q_o (cpu_rst_n)
  );
  rxpp_sync #(.W(1)) u_rst_mii (
    .clk_i (mii_clk_i), .rst_ni (rst_ni), .d_i (1'b1), .q_o (mii_rst_n)
  );

  rxpp_sync #(.W(2)) u_set_sync (
    .clk_i (clk_i),     .rst_ni (cpu_rst_n), .d_i (set_tgl), .q_o (set_sync)
  );
  rxpp_sync #(.W(2)) u_clr_sync (
    .clk_i (mii_clk_i), .rst_ni (mii_rst_n), .d_i (clr_tgl), .q_o (clr_sync)
  );
  // Error bits only ever rise, so per-bit synchronisation is safe.
  rxpp_sync #(.W(8)) u_err_sync (
    .clk_i (clk_i),     .rst_ni (cpu_rst_n), .d_i (err_mii), .q_o (err_o)
  );

  assign full_mii = set_tgl ^ clr_sync;

  rxpp_mii_rx #(
    .BUF_AW (BUF_AW), .LEN_W (LEN_W), .MIN_BYTES (MIN_BYTES)
  ) u_mii_rx (
    .clk_i     (mii_clk_i),
    .rst_ni    (mii_rst_n),
    .dv_i      (mii_dv_i),
    .d_i       (mii_d_i),
    .full_i    (full_mii),
    .we_o      (mem_we),
    .waddr_o   (mem_waddr),
    .wdata_o   (mem_wdata),
    .set_tgl_o (set_tgl),
    .len_o     (len_vec),
    .err_o     (err_mii)
  );

  rxpp_ram #(.AW (MEM_AW), .DW (32)) u_ram (
    .wclk_i  (mii_clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .rclk_i  (clk_i),
    .raddr_i (cpu_addr_i),
    .rdata_o (ram_q)
  );

  // The length of a half changes only while that half is empty, and the
  // processor side shows it only once the set toggle has been synchronised.
  rxpp_cpu_port #(.BUF_AW (BUF_AW), .LEN_W (LEN_W)) u_cpu_port (
    .clk_i      (clk_i),
    .rst_ni     (cpu_rst_n),
    .addr_i     (cpu_addr_i),
    .lane_i     (cpu_lane_i),
    .we_i       (cpu_we_i),
    .wdata_i    (cpu_wdata_i),
    .set_sync_i (set_sync),
    .len_i      (len_vec),
    .ram_q_i    (ram_q),
    .rdata_o    (cpu_rdata_o),
    .clr_tgl_o  (clr_tgl),
    .full_o     (full_cpu),
    .rel_o      (rel)
  );

endmodule

// File: rtl/rxpp_checker.sv
module rxpp_checker #(
  parameter int unsigned BUF_AW = 9
) (
  input logic            clk_i,
  input logic            mii_clk_i,
  input logic            cpu_rst_n,
  input logic            mii_rst_n,
  input logic            mem_we,
  input logic [BUF_AW:0] mem_waddr,
  input logic [1:0]      full_mii,
  input logic [1:0]      set_tgl,
  input logic [1:0]      full_cpu,
  input logic [1:0]      rel,
  input logic [7:0]      err_o
);

  assert_write_to_free_half_R6: assert property (@(posedge mii_clk_i) disable iff (!mii_rst_n)
    mem_we |-> !full_mii[mem_waddr[BUF_AW]]);

  assert_ctrl_slot_untouched_R3: assert property (@(posedge mii_clk_i) disable iff (!mii_rst_n)
    mem_we |-> (mem_waddr[BUF_AW-1:0] != '0));

  assert_single_publish_R4: assert property (@(posedge mii_clk_i) disable iff (!mii_rst_n)
    (set_tgl != $past(set_tgl)) |->
      (($countones(set_tgl ^ $past(set_tgl)) == 1) &&
       (($past(full_mii) & (set_tgl ^ $past(set_tgl))) == 2'b00)));

  assert_release_only_by_write0_R5: assert property (@(posedge clk_i) disable iff (!cpu_rst_n)
    $fell(full_cpu[0]) |-> $past(rel[0]));

  assert_release_only_by_write1_R5: assert property (@(posedge clk_i) disable iff (!cpu_rst_n)
    $fell(full_cpu[1]) |-> $past(rel[1]));

  assert_errors_sticky_R11: assert property (@(posedge clk_i) disable iff (!cpu_rst_n)
    (($past(err_o) & ~err_o) == 8'h00) && (err_o[7:4] == 4'h0));

endmodule

bind eth_rx_pingpong rxpp_checker #(.BUF_AW (BUF_AW)) u_chk (
  .clk_i     (clk_i),
  .mii_clk_i (mii_clk_i),
  .cpu_rst_n (cpu_rst_n),
  .mii_rst_n (mii_rst_n),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .full_mii  (full_mii),
  .set_tgl   (set_tgl),
  .full_cpu  (full_cpu),
  .rel       (rel),
  .err_o     (err_o)
);

// File: tb/eth_rx_pingpong_tb.sv
`timescale 1ns/1ps
module eth_rx_pingpong_tb;

  logic        clk_i = 1'b0;
  logic        mii_clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mii_dv_i = 1'b0;
  logic [3:0]  mii_d_i = 4'h0;
  logic [9:0]  cpu_addr_i = '0;
  logic [1:0]  cpu_lane_i = '0;
  logic [3:0]  cpu_we_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic [31:0] cpu_rdata_o;
  logic [7:0]  err_o;

  always #4  clk_i = ~clk_i;
  always #20 mii_clk_i = ~mii_clk_i;

  eth_rx_pingpong u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .mii_clk_i (mii_clk_i),
    .mii_dv_i (mii_dv_i), .mii_d_i (mii_d_i),
    .cpu_addr_i (cpu_addr_i), .cpu_lane_i (cpu_lane_i), .cpu_we_i (cpu_we_i),
    .cpu_wdata_i (cpu_wdata_i), .cpu_rdata_o (cpu_rdata_o), .err_o (err_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] fb [0:2100];
  logic [7:0] fb_keep [0:2100];
  int total = 0;
  int total_keep = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_read(input logic [9:0] a, input logic [1:0] ln, output logic [31:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_lane_i = ln; cpu_we_i = 4'h0;
    @(negedge clk_i);
    d = cpu_rdata_o;
  endtask

  task automatic cpu_write(input logic [9:0] a, input logic [3:0] we, input logic [31:0] wd);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_we_i = we; cpu_wdata_i = wd;
    @(negedge clk_i);
    cpu_we_i = 4'h0;
  endtask

  function automatic logic [31:0] ctrl_exp(input int len);
    return {1'b1, 3'b000, 12'(len), 16'h0000};
  endfunction

  // Builds the frame bytes (payload then FCS) and drives them onto the line.
  task automatic send_frame(input int npay, input logic [7:0] seed, input bit bad);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < npay; i++) begin
      fb[i] = 8'(seed + 8'(3 * i));
      for (int j = 0; j < 8; j++)
        c = ((c[0] ^ fb[i][j]) != 1'b0) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    c = ~c;
    for (int j = 0; j < 4; j++) fb[npay + j] = c[8*j +: 8];
    if (bad) fb[npay] = fb[npay] ^ 8'h01;
    total = npay + 4;
    for (int i = 0; i < 16; i++) begin
      @(negedge mii_clk_i);
      mii_dv_i = 1'b1;
      mii_d_i  = (i == 15) ? 4'hD : 4'h5;
    end
    for (int i = 0; i < total; i++) begin
      @(negedge mii_clk_i); mii_d_i = fb[i][3:0];
      @(negedge mii_clk_i); mii_d_i = fb[i][7:4];
    end
    @(negedge mii_clk_i);
    mii_dv_i = 1'b0; mii_d_i = 4'h0;
    repeat (12) @(negedge mii_clk_i);
  endtask

  task automatic chk_payload(input logic bsel, input string req);
    logic [31:0] got, exp, got_bad, exp_bad;
    bit found;
    found = 0; got_bad = 0; exp_bad = 0;
    for (int w = 0; w < (total + 3) / 4; w++) begin
      exp = 0;
      for (int k = 0; k < 4; k++)
        if (4 * w + k < total) exp[8*k +: 8] = fb[4 * w + k];
      cpu_read({bsel, 9'(w + 1)}, 2'd0, got);
      if (!found && got !== exp) begin
        found = 1; got_bad = got; exp_bad = exp;
      end
    end
    chk(req, got_bad, exp_bad);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    cpu_read(10'h000, 2'd0, d); chk("R1 ctrl half0", d, 32'h0);
    cpu_read(10'h200, 2'd0, d); chk("R1 ctrl half1", d, 32'h0);
    chk("R1 err", {24'h0, err_o}, 32'h0);
  endtask

  task automatic t_first_frame();
    logic [31:0] d;
    send_frame(60, 8'h10, 0);
    cpu_read(10'h000, 2'd0, d); chk("R3 ctrl half0", d, ctrl_exp(64));
    chk_payload(1'b0, "R2 payload half0");
    cpu_read(10'h001, 2'd2, d); chk("R10 lane2", d, {16'h0, fb[3], fb[2]});
    cpu_read(10'h001, 2'd1, d); chk("R10 lane1", d, {8'h0, fb[3], fb[2], fb[1]});
    cpu_read(10'h200, 2'd0, d); chk("R4 half1 still empty", d, 32'h0);
    chk("R7 R8 no error on good frame", {24'h0, err_o}, 32'h0);
    for (int i = 0; i <= 2100; i++) fb_keep[i] = fb[i];
    total_keep = total;
  endtask

  task automatic t_second_frame();
    logic [31:0] d;
    send_frame(69, 8'h80, 0);
    cpu_read(10'h200, 2'd0, d); chk("R4 ctrl half1", d, ctrl_exp(73));
    chk_payload(1'b1, "R2 partial last word half1");
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    send_frame(70, 8'h33, 0);
    chk("R6 overflow bit", {24'h0, err_o}, 32'h2);
    cpu_read(10'h000, 2'd0, d); chk("R6 half0 kept", d, ctrl_exp(64));
    cpu_read(10'h200, 2'd0, d); chk("R6 half1 kept", d, ctrl_exp(73));
    for (int i = 0; i <= 2100; i++) fb[i] = fb_keep[i];
    total = total_keep;
    chk_payload(1'b0, "R6 half0 payload kept");
  endtask

  task automatic t_release();
    logic [31:0] d;
    cpu_write(10'h000, 4'hF, 32'hFFFF_FFFF);
    cpu_read(10'h000, 2'd0, d); chk("R5 bit31 set ignored", d, ctrl_exp(64));
    cpu_write(10'h000, 4'h7, 32'h0);
    cpu_read(10'h000, 2'd0, d); chk("R5 no top lane ignored", d, ctrl_exp(64));
    cpu_write(10'h001, 4'hF, 32'h0);
    cpu_read(10'h001, 2'd0, d); chk("R5 payload write ignored", d, {fb[3], fb[2], fb[1], fb[0]});
    cpu_write(10'h000, 4'h8, 32'h0);
    cpu_read(10'h000, 2'd0, d); chk("R5 release half0", d, 32'h0);
    cpu_write(10'h200, 4'h8, 32'h0);
    cpu_read(10'h200, 2'd0, d); chk("R5 release half1", d, 32'h0);
  endtask

  task automatic t_short();
    logic [31:0] d;
    send_frame(16, 8'h5A, 0);
    cpu_read(10'h000, 2'd0, d); chk("R8 short stored half0", d, ctrl_exp(20));
    chk("R8 short bit", {24'h0, err_o}, 32'h6);
    chk_payload(1'b0, "R8 short payload");
    cpu_write(10'h000, 4'h8, 32'h0);
  endtask

  task automatic t_bad_crc();
    logic [31:0] d;
    send_frame(60, 8'hC1, 1);
    cpu_read(10'h200, 2'd0, d); chk("R7 bad crc stored half1", d, ctrl_exp(64));
    chk("R7 crc bit", {24'h0, err_o}, 32'h7);
    chk_payload(1'b1, "R7 bad crc payload");
    cpu_write(10'h200, 4'h8, 32'h0);
  endtask

  task automatic t_oversize();
    logic [31:0] d;
    send_frame(2045, 8'h07, 0);
    cpu_read(10'h000, 2'd0, d); chk("R9 half0 not full", d, 32'h0);
    cpu_read(10'h200, 2'd0, d); chk("R9 half1 not full", d, 32'h0);
    chk("R9 oversize bit", {24'h0, err_o}, 32'hF);
  endtask

  task automatic t_resume();
    logic [31:0] d;
    send_frame(100, 8'h44, 0);
    cpu_read(10'h000, 2'd0, d); chk("R4 order after drops half0", d, ctrl_exp(104));
    cpu_read(10'h200, 2'd0, d); chk("R4 half1 empty", d, 32'h0);
    chk_payload(1'b0, "R2 payload after drops");
    chk("R11 errors held", {24'h0, err_o}, 32'hF);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) @(negedge mii_clk_i);
    t_reset();
    t_first_frame();
    t_second_frame();
    t_overflow();
    t_release();
    t_short();
    t_bad_crc();
    t_oversize();
    t_resume();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule